// File: doc/BRIEF.md
# Dual-Master Interrupt Status and Mask Unit

This unit sits beside a two-owner bus selector and tells each master what happened to the shared downstream bus. For each master it keeps three things: a status register of sticky event flags, a mask register, and a control register whose low bit forces a functional test. It also drives one active-low interrupt line per master. The ownership controller sends it single-cycle event pulses, and each pulse carries the index of the master it concerns. A bus-lost pulse is aimed at the master that was just disconnected. An init-done pulse and a bus-dirty pulse (the bus was not idle at switch time) are aimed at the new owner. When the bus was idle at the switch, the controller sends no pulse, so no interrupt is raised.

Register access uses plain strobes. A write is first staged. It is applied only on a separate commit strobe, which stands for the acknowledge edge of the ninth serial clock. Reads are combinational from a master index and a register selector. A master's interrupt line is low when any unmasked status flag is set, or when its test bit is set.

Top module: `mis_top`

## Requirements
- R1: After reset every status, mask and control register reads 0 and both `irq_n` lines are high.
- R2: An `evt_lost` pulse sets status bit 0 of master `evt_lost_mst` on the next clock edge and leaves the other master's status unchanged.
- R3: An `evt_init` pulse sets status bit 1 of master `evt_new_mst`.
- R4: An `evt_dirty` pulse sets status bit 2 of master `evt_new_mst`.
- R5: A status bit whose mask bit (same position, selector 1) is 1 is still set and readable, but it does not pull that master's `irq_n` low. An unmasked set bit pulls it low.
- R6: Writing the status register (selector 0) clears each bit written as 1 and leaves bits written as 0 untouched.
- R7: When an event and a status clear hit the same bit in the same cycle, the bit ends up set.
- R8: Control bit 0 (selector 2) being 1 holds that master's `irq_n` low whatever its status and mask.
- R9: A write loaded with `wr_en` changes no register until `wr_commit` is pulsed. A commit with nothing staged changes nothing.
- R10: Reading selector 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_lost | input | 1 | Bus-lost event pulse |
| evt_lost_mst | input | 1 | Master that lost the bus |
| evt_init | input | 1 | Initialization-complete event pulse |
| evt_dirty | input | 1 | Bus-not-idle-at-switch event pulse |
| evt_new_mst | input | 1 | New owner for init and dirty events |
| wr_en | input | 1 | Stage a register write |
| wr_mst | input | 1 | Target master of the staged write |
| wr_sel | input | 2 | Register selector: 0 status, 1 mask, 2 control |
| wr_data | input | 3 | Write data |
| wr_commit | input | 1 | Acknowledge-edge strobe that applies the staged write |
| rd_mst | input | 1 | Master being read |
| rd_sel | input | 2 | Register selector for reads |
| rd_data | output | 3 | Read data |
| irq_n | output | 2 | Active-low interrupt, one per master |

## Verification
An event pulse and the commit of a status clear can land in the same cycle, on the same master and even on the same bit. The bench sets up this collision deliberately. It pre-sets two flags, stages a clear of both, then raises an event on one of them in the same cycle as the commit. The flag that was hit by the event must survive and the other must clear. Around this, the bench sweeps every master, source, mask and test combination and computes the expected status word and interrupt levels.

// File: rtl/mis_pkg.sv
package mis_pkg;
   typedef enum logic [1:0] {
      SEL_STAT = 2'd0,
      SEL_MASK = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   localparam int SRC_LOST  = 0;
   localparam int SRC_INIT  = 1;
   localparam int SRC_DIRTY = 2;
   localparam int CTL_TEST  = 0;
endpackage

// File: rtl/mis_wr_stage.sv
module mis_wr_stage #(
   parameter int IDX_W = 1,
   parameter int DW    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_mst,
   input  logic [1:0]       wr_sel,
   input  logic [DW-1:0]    wr_data,
   input  logic             wr_commit,
   output logic             cmt_vld,
   output logic [IDX_W-1:0] cmt_mst,
   output logic [1:0]       cmt_sel,
   output logic [DW-1:0]    cmt_data
);
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q   <= 1'b0;
         cmt_mst  <= '0;
         cmt_sel  <= '0;
         cmt_data <= '0;
      end else if (wr_en) begin
         pend_q   <= 1'b1;
         cmt_mst  <= wr_mst;
         cmt_sel  <= wr_sel;
         cmt_data <= wr_data;
      end else if (wr_commit) begin
         pend_q   <= 1'b0;
      end
   end

   assign cmt_vld = wr_commit && pend_q && !wr_en;

   a_r9_commit_consumes: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt_vld) |=> !pend_q);
endmodule

// File: rtl/mis_src_bank.sv
module mis_src_bank #(
   parameter int N_SRC = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] set_i,
   input  logic [N_SRC-1:0] clr_i,
   input  logic             mask_we,
   input  logic             ctl_we,
   input  logic [N_SRC-1:0] wdata_i,
   output logic [N_SRC-1:0] status_o,
   output logic [N_SRC-1:0] mask_o,
   output logic [N_SRC-1:0] ctl_o,
   output logic             irq_n_o
);
   logic [N_SRC-1:0] status_q, mask_q, ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         mask_q   <= '0;
         ctl_q    <= '0;
      end else begin
         status_q <= (status_q & ~clr_i) | set_i;
         if (mask_we) mask_q <= wdata_i;
         if (ctl_we)  ctl_q  <= wdata_i;
      end
   end

   assign status_o = status_q;
   assign mask_o   = mask_q;
   assign ctl_o    = ctl_q;
   assign irq_n_o  = !((|(status_q & ~mask_q)) || ctl_q[mis_pkg::CTL_TEST]);

   a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((status_q & $past(set_i)) == $past(set_i)));

   a_r6_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(status_q) & ~status_q & ~$past(clr_i)) == '0));

   a_r9_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_we |=> $stable(mask_q));

   a_r9_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_we |=> $stable(ctl_q));
endmodule

// File: rtl/mis_top.sv
module mis_top #(
   parameter int N_MST = 2,
   parameter int N_SRC = 3,
   localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_lost,
   input  logic [IDX_W-1:0] evt_lost_mst,
   input  logic             evt_init,
   input  logic             evt_dirty,
   input  logic [IDX_W-1:0] evt_new_mst,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_mst,
   input  logic [1:0]       wr_sel,
   input  logic [N_SRC-1:0] wr_data,
   input  logic             wr_commit,
   input  logic [IDX_W-1:0] rd_mst,
   input  logic [1:0]       rd_sel,
   output logic [N_SRC-1:0] rd_data,
   output logic [N_MST-1:0] irq_n
);
   import mis_pkg::*;

   if (N_MST < 2) begin : g_bad_mst
      $error("mis_top: N_MST must be at least 2");
   end
   if (N_SRC < 3) begin : g_bad_src
      $error("mis_top: N_SRC must be at least 3");
   end

   logic             cmt_vld;
   logic [IDX_W-1:0] cmt_mst;
   logic [1:0]       cmt_sel;
   logic [N_SRC-1:0] cmt_data;

   mis_wr_stage #(.IDX_W(IDX_W), .DW(N_SRC)) u_stage (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_mst(wr_mst), .wr_sel(wr_sel), .wr_data(wr_data),
      .wr_commit(wr_commit),
      .cmt_vld(cmt_vld), .cmt_mst(cmt_mst), .cmt_sel(cmt_sel), .cmt_data(cmt_data)
   );

   logic [N_SRC-1:0] st_a   [N_MST];
   logic [N_SRC-1:0] mk_a   [N_MST];
   logic [N_SRC-1:0] ct_a   [N_MST];

   for (genvar m = 0; m < N_MST; m++) begin : g_mst
      logic [N_SRC-1:0] set_v, clr_v;
      logic             hit;

      always_comb begin
         set_v = '0;
         set_v[SRC_LOST]  = evt_lost  && (evt_lost_mst == IDX_W'(m));
         set_v[SRC_INIT]  = evt_init  && (evt_new_mst  == IDX_W'(m));
         set_v[SRC_DIRTY] = evt_dirty && (evt_new_mst  == IDX_W'(m));
      end

      assign hit   = cmt_vld && (cmt_mst == IDX_W'(m));
      assign clr_v = (hit && cmt_sel == SEL_STAT) ? cmt_data : '0;

      mis_src_bank #(.N_SRC(N_SRC)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .set_i(set_v), .clr_i(clr_v),
         .mask_we(hit && cmt_sel == SEL_MASK),
         .ctl_we(hit && cmt_sel == SEL_CTRL),
         .wdata_i(cmt_data),
         .status_o(st_a[m]), .mask_o(mk_a[m]), .ctl_o(ct_a[m]),
         .irq_n_o(irq_n[m])
      );

      a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         (((st_a[m] & ~mk_a[m]) == '0) && !ct_a[m][CTL_TEST]) |-> irq_n[m]);
   end

   always_comb begin
      rd_data = '0;
      for (int m = 0; m < N_MST; m++) begin
         if (rd_mst == IDX_W'(m)) begin
            case (rd_sel)
               SEL_STAT: rd_data = st_a[m];
               SEL_MASK: rd_data = mk_a[m];
               SEL_CTRL: rd_data = ct_a[m];
               default:  rd_data = '0;
            endcase
         end
      end
   end
endmodule

// File: tb/sim_mis_top.sv
module sim_mis_top;
   localparam int CLK_PER = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic evt_lost = 0, evt_lost_mst = 0, evt_init = 0, evt_dirty = 0, evt_new_mst = 0;
   logic wr_en = 0, wr_mst = 0, wr_commit = 0, rd_mst = 0;
   logic [1:0] wr_sel = 0, rd_sel = 0;
   logic [2:0] wr_data = 0, rd_data;
   logic [1:0] irq_n;
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #(CLK_PER/2) clk = ~clk;

   mis_top u0 (.*);

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic m, input logic [1:0] s, output logic [2:0] v);
      rd_mst = m; rd_sel = s; #1; v = rd_data;
   endtask

   task automatic stage(input logic m, input logic [1:0] s, input logic [2:0] d);
      @(negedge clk); wr_en = 1; wr_mst = m; wr_sel = s; wr_data = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic wr(input logic m, input logic [1:0] s, input logic [2:0] d);
      stage(m, s, d);
      wr_commit = 1;
      @(negedge clk); wr_commit = 0;
   endtask

   task automatic fire(input int src, input logic m);
      @(negedge clk);
      evt_lost = (src == 0); evt_init = (src == 1); evt_dirty = (src == 2);
      evt_lost_mst = m; evt_new_mst = m;
      @(negedge clk);
      evt_lost = 0; evt_init = 0; evt_dirty = 0;
   endtask

   initial begin
      logic [2:0] v;
      #(CLK_PER*3); @(negedge clk); rst_n = 1;
      for (int m = 0; m < 2; m++)
         for (int s = 0; s < 4; s++) begin
            rd(m[0], s[1:0], v);
            chk("R1 reset regs", v, 0);
         end
      chk("R1 reset irq", irq_n, 2'b11);

      // sweep: master x source x mask x test
      for (int m = 0; m < 2; m++)
         for (int s = 0; s < 3; s++)
            for (int mk = 0; mk < 2; mk++)
               for (int t = 0; t < 2; t++) begin
                  logic [2:0] mval;
                  logic [1:0] exp_irq;
                  mval = mk ? 3'(1 << s) : 3'b000;
                  wr(m[0], 2'd1, mval);
                  wr(m[0], 2'd2, 3'(t));
                  fire(s, m[0]);
                  rd(m[0], 2'd0, v);
                  chk(s == 0 ? "R2 status" : (s == 1 ? "R3 status" : "R4 status"), v, 1 << s);
                  rd(!m[0], 2'd0, v);
                  chk("R2 other master untouched", v, 0);
                  exp_irq = 2'b11;
                  if (!mk || t) exp_irq[m] = 1'b0;
                  chk(t ? "R8 test forces" : "R5 mask gating", irq_n, exp_irq);
                  wr(m[0], 2'd0, 3'b111);
                  wr(m[0], 2'd2, 3'b000);
                  wr(m[0], 2'd1, 3'b000);
                  rd(m[0], 2'd0, v);
                  chk("R6 full clear", v, 0);
               end

      // R8 test bit alone with empty status
      wr(1'b1, 2'd2, 3'b001);
      chk("R8 test with no status", irq_n, 2'b01);
      wr(1'b1, 2'd2, 3'b000);
      chk("R8 test release", irq_n, 2'b11);

      // R6 partial clear
      fire(0, 1'b0); fire(1, 1'b0);
      wr(1'b0, 2'd0, 3'b010);
      rd(1'b0, 2'd0, v);
      chk("R6 partial clear", v, 3'b001);
      wr(1'b0, 2'd0, 3'b111);

      // R7 collision: bits 0,1 set; clear both while lost event hits bit 0
      fire(0, 1'b0); fire(1, 1'b0);
      stage(1'b0, 2'd0, 3'b011);
      wr_commit = 1; evt_lost = 1; evt_lost_mst = 0;
      @(negedge clk); wr_commit = 0; evt_lost = 0;
      rd(1'b0, 2'd0, v);
      chk("R7 set beats clear", v, 3'b001);
      wr(1'b0, 2'd0, 3'b111);

      // R9 staging
      stage(1'b0, 2'd1, 3'b111);
      @(negedge clk);
      rd(1'b0, 2'd1, v);
      chk("R9 staged not applied", v, 0);
      wr_commit = 1; @(negedge clk); wr_commit = 0;
      rd(1'b0, 2'd1, v);
      chk("R9 applied on commit", v, 3'b111);
      wr_commit = 1; @(negedge clk); wr_commit = 0;
      rd(1'b0, 2'd1, v);
      chk("R9 empty commit no change", v, 3'b111);
      wr(1'b0, 2'd1, 3'b000);

      // R10 unused selector
      fire(2, 1'b1);
      rd(1'b1, 2'd3, v);
      chk("R10 selector 3 reads zero", v, 0);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule